// File: doc/BRIEF.md
# Memory ECC Error Logger

This block keeps a record of memory read errors flagged by an ECC checker placed upstream of it. Each cycle the checker can present an error strobe together with the class of the fault (one bit corrected, or two bits uncorrectable), a 7-bit syndrome and the 32-bit address of the read that failed. The first error after a clear is captured in full: the failing address goes into a 32-bit address register, and the class and syndrome go into a 12-bit status register. Any error after that only raises a sticky flag that says more than one error has occurred since the log was last cleared.

Software reads the log through a simple register read port. Offset 0 returns the address and offset 1 returns the status, zero-extended. A write to offset 3 empties both registers. The status register is also driven out on its own port for a debug view. The ECC encode and decode logic and the bus packet handling sit outside this block.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous active-low reset, the status register and the address register both read as zero.
- R2: A single-bit error presented while the log is empty loads the log at the next clock edge. The status becomes (syndrome << 5) | 2, where bit 1 marks the single-bit class, and the address register takes the request address.
- R3: A double-bit error presented while the log is empty loads the log at the next clock edge. The status becomes (syndrome << 5) | 8, where bit 3 marks the double-bit class, and the syndrome is the XOR of the two failing bit indices as supplied.
- R4: An error presented while an error is already logged sets only status bit 0. The address, class bits and syndrome keep their values, so a single error followed by more reads as class value 3 and a double error followed by more reads as 9.
- R5: An I/O write to offset 3 clears both the status and the address register at the next clock edge.
- R6: An I/O write to any offset other than 3 changes neither register.
- R7: An I/O read at offset 0 returns the address register and a read at offset 1 returns the status zero-extended to 32 bits. Reads at other offsets return zero, and reading never changes either register.
- R8: If a clear and an error arrive in the same cycle, the error is logged as a first error, with bit 0 clear.
- R9: The debug status output always equals the status register as read at offset 1.
- R10: Status bits 2 and 4 always read zero, and at most one of the two class bits (1 and 3) is set at any time.
- R11: Status bit 0 is never set unless a class bit is also set, and it stays set until a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_vld | input | 1 | An ECC error is reported this cycle |
| err_dbl | input | 1 | Error class: 0 single-bit corrected, 1 double-bit uncorrectable |
| err_syn | input | 7 | Failing bit index (single) or XOR of the two indices (double) |
| err_addr | input | 32 | Address of the read that failed |
| io_wr_en | input | 1 | I/O register write strobe |
| io_wr_off | input | 2 | I/O write offset; 3 clears the log |
| io_rd_off | input | 2 | I/O read offset; 0 address, 1 status |
| io_rd_data | output | 32 | I/O read data for io_rd_off |
| dbg_status | output | 12 | Live copy of the status register for the debug port |

## Verification
The bench goes after the order in which events reach the log. A second error with a different address and syndrome must leave the first record intact, so a design that overwrote the log would show the later address. A clear that arrives together with an error must keep the new error as a fresh first entry, so a design that gave priority to the clear would read zero, and one that treated the error as a follow-on would set the multiple-error flag on an empty log. Writes to offsets other than 3 and repeated reads are checked to leave the registers unchanged, which catches a clear decoded on too few offset bits and a read that clears the log as a side effect.

// File: rtl/ecc_log_pkg.sv
// Shared constants for the ECC error logger: status bit positions and I/O offsets.
package ecc_log_pkg;
    // Status register bit positions; software decodes these.
    localparam int ST_MULTI  = 0;  // further errors seen after the first
    localparam int ST_SINGLE = 1;  // first error was a corrected single-bit error
    localparam int ST_DOUBLE = 3;  // first error was an uncorrectable double-bit error
    localparam int ST_SYN_LO = 5;  // syndrome field starts here

    // Decoded action for one cycle of the logger.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_FIRST = 2'd1,
        ACT_MORE  = 2'd2,
        ACT_CLEAR = 2'd3
    } log_act_e;
endpackage

// File: rtl/ecc_log_ctrl.sv
// Decides per cycle what the log does: load a first error, flag a further one,
// clear, or hold. Assumes err_vld and the clear request are single-cycle qualified.
// A clear and an error in the same cycle give a fresh first load.
module ecc_log_ctrl
    import ecc_log_pkg::*;
(
    input  logic     err_vld,
    input  logic     clr_req,
    input  logic     logged,
    output log_act_e act
);
    // Priority: an error beside a clear restarts the log, else clear, else flag.
    always_comb begin
        if (err_vld && (clr_req || !logged)) act = ACT_FIRST;
        else if (clr_req)                    act = ACT_CLEAR;
        else if (err_vld)                    act = ACT_MORE;
        else                                 act = ACT_IDLE;
    end
endmodule

// File: rtl/ecc_log_status.sv
// Holds the class bits, the sticky multiple-error flag and the syndrome, and
// packs them into the status word. Assumes STAT_W >= ST_SYN_LO + SYN_W.
module ecc_log_status
    import ecc_log_pkg::*;
#(
    parameter int SYN_W  = 7,
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  log_act_e          act,
    input  logic              err_dbl,
    input  logic [SYN_W-1:0]  err_syn,
    output logic [STAT_W-1:0] status,
    output logic              logged
);
    logic             sgl_q, dbl_q, multi_q;
    logic [SYN_W-1:0] syn_q;

    // Update the status fields according to the cycle's action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgl_q   <= 1'b0;
            dbl_q   <= 1'b0;
            multi_q <= 1'b0;
            syn_q   <= '0;
        end else begin
            case (act)
                ACT_FIRST: begin
                    sgl_q   <= !err_dbl;
                    dbl_q   <= err_dbl;
                    multi_q <= 1'b0;
                    syn_q   <= err_syn;
                end
                ACT_CLEAR: begin
                    sgl_q   <= 1'b0;
                    dbl_q   <= 1'b0;
                    multi_q <= 1'b0;
                    syn_q   <= '0;
                end
                ACT_MORE:  multi_q <= 1'b1;
                default:   ;
            endcase
        end
    end

    // Pack fields into their fixed bit positions; unused bits stay zero.
    always_comb begin
        status                        = '0;
        status[ST_MULTI]              = multi_q;
        status[ST_SINGLE]             = sgl_q;
        status[ST_DOUBLE]             = dbl_q;
        status[ST_SYN_LO +: SYN_W]    = syn_q;
    end

    // The log is occupied once either class bit is set.
    assign logged = sgl_q | dbl_q;
endmodule

// File: rtl/ecc_log_addr.sv
// Address register of the first failing read. Loads on a first error, zeroes on clear.
module ecc_log_addr
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  log_act_e          act,
    input  logic [ADDR_W-1:0] err_addr,
    output logic [ADDR_W-1:0] addr_q
);
    // Capture only the first failing address; later errors leave it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= '0;
        else if (act == ACT_FIRST)  addr_q <= err_addr;
        else if (act == ACT_CLEAR)  addr_q <= '0;
    end
endmodule

// File: rtl/ecc_log_rdmux.sv
// Read-port multiplexer: selects address or status by offset, zero-extending to IO_W.
// Assumes IO_W is at least ADDR_W and STAT_W. Unmapped offsets read zero.
module ecc_log_rdmux #(
    parameter int ADDR_W   = 32,
    parameter int STAT_W   = 12,
    parameter int OFF_W    = 2,
    parameter int IO_W     = 32,
    parameter int OFF_ADDR = 0,
    parameter int OFF_STAT = 1
) (
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [STAT_W-1:0] status,
    output logic [IO_W-1:0]   rd_data
);
    localparam logic [OFF_W-1:0] SEL_ADDR = OFF_W'(OFF_ADDR);
    localparam logic [OFF_W-1:0] SEL_STAT = OFF_W'(OFF_STAT);

    // Pick the register addressed by the read offset.
    always_comb begin
        if (rd_off == SEL_ADDR)      rd_data = IO_W'(addr_q);
        else if (rd_off == SEL_STAT) rd_data = IO_W'(status);
        else                         rd_data = '0;
    end
endmodule

// File: rtl/ecc_err_log.sv
// Top of the ECC error logger. Logs the first ECC error in full, flags later
// ones, exposes both registers on a read port and clears them on a write to
// the clear offset. Assumes all inputs are synchronous to clk.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SYN_W   = 7,
    parameter int STAT_W  = 12,
    parameter int OFF_W   = 2,
    parameter int IO_W    = 32,
    parameter int OFF_ADDR = 0,
    parameter int OFF_STAT = 1,
    parameter int OFF_CLR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_vld,
    input  logic              err_dbl,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              io_wr_en,
    input  logic [OFF_W-1:0]  io_wr_off,
    input  logic [OFF_W-1:0]  io_rd_off,
    output logic [IO_W-1:0]   io_rd_data,
    output logic [STAT_W-1:0] dbg_status
);
    localparam logic [OFF_W-1:0] SEL_CLR = OFF_W'(OFF_CLR);

    logic              clr_req;
    logic              logged;
    log_act_e          act;
    logic [STAT_W-1:0] status;
    logic [ADDR_W-1:0] err_addr_q;

    // Decode the clear request from the write port.
    assign clr_req = io_wr_en && (io_wr_off == SEL_CLR);

    ecc_log_ctrl u_ctrl (
        .err_vld (err_vld),
        .clr_req (clr_req),
        .logged  (logged),
        .act     (act)
    );

    ecc_log_status #(.SYN_W(SYN_W), .STAT_W(STAT_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .err_dbl (err_dbl),
        .err_syn (err_syn),
        .status  (status),
        .logged  (logged)
    );

    ecc_log_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .err_addr (err_addr),
        .addr_q   (err_addr_q)
    );

    ecc_log_rdmux #(
        .ADDR_W(ADDR_W), .STAT_W(STAT_W), .OFF_W(OFF_W), .IO_W(IO_W),
        .OFF_ADDR(OFF_ADDR), .OFF_STAT(OFF_STAT)
    ) u_rdmux (
        .rd_off  (io_rd_off),
        .addr_q  (err_addr_q),
        .status  (status),
        .rd_data (io_rd_data)
    );

    // Debug view is the live status word.
    assign dbg_status = status;
endmodule

// File: rtl/ecc_err_log_chk.sv
// Property checker for the ECC error logger, bound onto the top module.
module ecc_err_log_chk #(
    parameter int ADDR_W  = 32,
    parameter int SYN_W   = 7,
    parameter int STAT_W  = 12,
    parameter int OFF_W   = 2,
    parameter int OFF_CLR = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_vld,
    input logic              err_dbl,
    input logic [SYN_W-1:0]  err_syn,
    input logic              io_wr_en,
    input logic [OFF_W-1:0]  io_wr_off,
    input logic [STAT_W-1:0] dbg_status,
    input logic [ADDR_W-1:0] addr_q
);
    logic clr_in;
    logic full;
    assign clr_in = io_wr_en && (io_wr_off == OFF_W'(OFF_CLR));
    assign full   = dbg_status[1] || dbg_status[3];

    // R2
    first_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !err_dbl && !full && !clr_in) |=>
        (dbg_status == STAT_W'({$past(err_syn), 5'b00010})));

    // R3
    first_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && err_dbl && !full && !clr_in) |=>
        (dbg_status == STAT_W'({$past(err_syn), 5'b01000})));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr_in) |=> $stable(addr_q));

    // R4
    more_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && full && !clr_in) |=>
        (dbg_status[0] && (dbg_status[STAT_W-1:1] == $past(dbg_status[STAT_W-1:1]))));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && !err_vld) |=> (dbg_status == '0 && addr_q == '0));

    // R8
    clear_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && err_vld) |=> (!dbg_status[0] && full));

    // R10
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0({dbg_status[3], dbg_status[1]}) && !dbg_status[2] && !dbg_status[4]));

    // R11
    multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status[0] && !clr_in) |=> (dbg_status[0] && full));
endmodule

bind ecc_err_log ecc_err_log_chk #(
    .ADDR_W(ADDR_W), .SYN_W(SYN_W), .STAT_W(STAT_W), .OFF_W(OFF_W), .OFF_CLR(OFF_CLR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_vld    (err_vld),
    .err_dbl    (err_dbl),
    .err_syn    (err_syn),
    .io_wr_en   (io_wr_en),
    .io_wr_off  (io_wr_off),
    .dbg_status (dbg_status),
    .addr_q     (err_addr_q)
);

// File: tb/ecc_err_log_tb_top.sv
// Directed bench for the ECC error logger: one task per scenario.
module ecc_err_log_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_vld = 1'b0;
    logic        err_dbl = 1'b0;
    logic [6:0]  err_syn = '0;
    logic [31:0] err_addr = '0;
    logic        io_wr_en = 1'b0;
    logic [1:0]  io_wr_off = '0;
    logic [1:0]  io_rd_off = '0;
    logic [31:0] io_rd_data;
    logic [11:0] dbg_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ecc_err_log dut_i (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_dbl(err_dbl),
        .err_syn(err_syn), .err_addr(err_addr), .io_wr_en(io_wr_en),
        .io_wr_off(io_wr_off), .io_rd_off(io_rd_off),
        .io_rd_data(io_rd_data), .dbg_status(dbg_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] off, output logic [31:0] val);
        io_rd_off = off;
        #1 val = io_rd_data;
    endtask

    // One error pulse; outputs settle by the following falling edge.
    task automatic err(input logic dbl, input logic [6:0] syn, input logic [31:0] a);
        @(negedge clk);
        err_vld = 1'b1; err_dbl = dbl; err_syn = syn; err_addr = a;
        @(negedge clk);
        err_vld = 1'b0; err_dbl = 1'b0; err_syn = '0; err_addr = '0;
    endtask

    task automatic wr(input logic [1:0] off);
        @(negedge clk);
        io_wr_en = 1'b1; io_wr_off = off;
        @(negedge clk);
        io_wr_en = 1'b0; io_wr_off = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 addr", v, 32'h0);
        rd(2'd1, v); check("R1 status", v, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        err(1'b0, 7'd62, 32'h0000_00F0);
        rd(2'd1, v); check("R2 status", v, (32'd62 << 5) | 32'd2);
        rd(2'd0, v); check("R2 addr", v, 32'h0000_00F0);
        check("R9 dbg", {20'h0, dbg_status}, v == 32'hF0 ? (32'd62 << 5) | 32'd2 : 32'hDEAD);
    endtask

    task automatic t_more_single();
        logic [31:0] v;
        err(1'b1, 7'd5, 32'h1234_5678);
        rd(2'd1, v); check("R4 status", v, (32'd62 << 5) | 32'd3);
        rd(2'd0, v); check("R4 addr", v, 32'h0000_00F0);
        err(1'b0, 7'd9, 32'h0000_0040);
        rd(2'd1, v); check("R11 sticky", v, (32'd62 << 5) | 32'd3);
    endtask

    task automatic t_read_only();
        logic [31:0] v;
        rd(2'd2, v); check("R7 unmapped", v, 32'h0);
        @(negedge clk); @(negedge clk);
        rd(2'd1, v); check("R7 no clear on read", v, (32'd62 << 5) | 32'd3);
        rd(2'd0, v); check("R7 addr read", v, 32'h0000_00F0);
    endtask

    task automatic t_other_writes();
        logic [31:0] v;
        wr(2'd0); wr(2'd1); wr(2'd2);
        rd(2'd1, v); check("R6 status", v, (32'd62 << 5) | 32'd3);
        rd(2'd0, v); check("R6 addr", v, 32'h0000_00F0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(2'd3);
        rd(2'd1, v); check("R5 status", v, 32'h0);
        rd(2'd0, v); check("R5 addr", v, 32'h0);
    endtask

    task automatic t_double();
        logic [31:0] v;
        err(1'b1, 7'(62 ^ 66), 32'h0000_00F0);
        rd(2'd1, v); check("R3 status", v, (32'(62 ^ 66) << 5) | 32'd8);
        check("R10 bits", {20'h0, dbg_status} & 32'h14, 32'h0);
        err(1'b1, 7'd1, 32'h0000_0100);
        rd(2'd1, v); check("R4 double more", v, (32'(62 ^ 66) << 5) | 32'd9);
        check("R9 dbg", {20'h0, dbg_status}, v);
    endtask

    task automatic t_clear_with_err();
        logic [31:0] v;
        @(negedge clk);
        io_wr_en = 1'b1; io_wr_off = 2'd3;
        err_vld = 1'b1; err_dbl = 1'b0; err_syn = 7'd17; err_addr = 32'hABCD_0000;
        @(negedge clk);
        io_wr_en = 1'b0; io_wr_off = '0; err_vld = 1'b0; err_syn = '0; err_addr = '0;
        rd(2'd1, v); check("R8 status", v, (32'd17 << 5) | 32'd2);
        rd(2'd0, v); check("R8 addr", v, 32'hABCD_0000);
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd1, v); check("R1 status after reset", v, 32'h0);
        rd(2'd0, v); check("R1 addr after reset", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_more_single();
        t_read_only();
        t_other_writes();
        t_clear();
        t_double();
        t_clear();
        t_clear_with_err();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule